// File: doc/BRIEF.md
# Decimal accumulator processor core

This block is a small accumulator processor whose registers and memory words all hold decimal numbers. Each digit is stored as a 4-bit packed BCD nibble. A data word has four digits and an address has three. The core fetches and executes instructions from a 1000-word on-chip memory. Every instruction runs as a fixed chain of register transfers through a memory address register (MAR) and a memory buffer register (MBR). Three operations exist: load the accumulator, store the accumulator, and add a memory word to the accumulator. All other opcode digits stop the core.

At the end of every instruction the core looks at its interrupt request line. If a request is pending and no handler is running, the core saves the program counter and the accumulator into shadow registers and jumps to a handler address set by a parameter. A program image is written through a loader port, which works only while reset is held. After reset is released, the registers are visible on a set of debug outputs.

Top module: `dec_acc_core`

## Requirements
- R1: While reset is asserted and straight after it, the program counter, instruction register, accumulator, address and buffer registers read zero, and the halt, overflow and handler-active outputs read 0.
- R2: Fetch copies the program counter into the address register, reads memory into the buffer register, copies that into the instruction register, then adds one to the program counter in decimal. The counter wraps from 999 to 000.
- R3: An instruction whose top digit is 1 loads the accumulator with the word at the address held in its low three digits.
- R4: Top digit 3 adds the addressed word to the accumulator digit by digit in decimal, modulo 10000. Each add sets the overflow output to 1 when a carry leaves the fourth digit and clears it to 0 otherwise.
- R5: Top digit 2 writes the accumulator into memory at the addressed location.
- R6: Top digits 0 and 4 to 9 stop the core. The halt output is then held at 1, and all registers are held, until reset. The program counter then points one past the stopping instruction.
- R7: After the execute steps of each instruction, a request on the interrupt line copies the program counter and the accumulator into shadow registers and loads the program counter with the handler address. This happens before the next fetch.
- R8: Once a handler has been entered, the handler-active output stays at 1 and the interrupt line is ignored until reset.
- R9: Loader writes take effect only while reset is asserted. A loader write while the core runs changes no memory word.
- R10: An executed instruction takes 8 clock cycles. A stopping instruction raises the halt output 4 cycles after its fetch starts. The first fetch starts on the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, sampled at the end of each instruction |
| ld_en | input | 1 | Loader write strobe, honoured only while rst_n is low |
| ld_addr | input | 12 | Loader address, 3 BCD digits |
| ld_data | input | 16 | Loader data, 4 BCD digits |
| halted | output | 1 | Core has stopped on an invalid opcode |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_ac | output | 16 | Accumulator |
| dbg_mar | output | 12 | Memory address register |
| dbg_mbr | output | 16 | Memory buffer register |
| dbg_ovf | output | 1 | Carry out of the last add |
| dbg_in_isr | output | 1 | Handler active |
| dbg_sav_pc | output | 12 | Saved program counter |
| dbg_sav_ac | output | 16 | Saved accumulator |

## Verification
The hardest case to reach from the ports is the program counter wrapping from 999 to 000, especially when that wrap happens inside an interrupt handler. Reaching it from address 000 by straight-line code would take about a thousand instructions. The bench instead sets the handler address to 998 and holds the interrupt line high from the first instruction. The core therefore enters the handler at once, runs through 998 and 999, wraps into the main program, and must then ignore the still-asserted request. The add path is swept over a grid of operand pairs, plus corner values such as 9999+0001. During each of these runs the loader port is driven against the addend, which checks that it is ignored.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int W_DIGITS = 4;
  localparam int A_DIGITS = 3;
  localparam int WORD_W   = 4 * W_DIGITS;
  localparam int ADDR_W   = 4 * A_DIGITS;

  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;

  typedef enum logic [3:0] {
    S_FMAR, S_FMBR, S_FIR, S_FPC,
    S_XMAR, S_XMBR, S_XFIN, S_CHK, S_HALT
  } state_e;

  // one decimal digit plus carry in; result is {carry_out, digit}
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] a,
                                               input logic [3:0] b,
                                               input logic       cin);
    logic [4:0] t;
    t = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (t > 5'd9) bcd_digit_add = {1'b1, 4'(t - 5'd10)};
    else          bcd_digit_add = {1'b0, t[3:0]};
  endfunction

  // decimal increment of an address, wrapping at the top
  function automatic logic [ADDR_W-1:0] bcd_inc_addr(input logic [ADDR_W-1:0] x);
    logic [ADDR_W-1:0] r;
    logic              c;
    r = x;
    c = 1'b1;
    for (int d = 0; d < A_DIGITS; d++) begin
      if (c) begin
        if (x[4*d +: 4] == 4'd9) begin
          r[4*d +: 4] = 4'd0;
        end else begin
          r[4*d +: 4] = x[4*d +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    bcd_inc_addr = r;
  endfunction

  // decimal address to a linear memory index
  function automatic int unsigned bcd_to_index(input logic [ADDR_W-1:0] x);
    int unsigned acc;
    acc = 0;
    for (int d = A_DIGITS - 1; d >= 0; d--)
      acc = acc * 10 + int'(x[4*d +: 4]);
    bcd_to_index = acc;
  endfunction
endpackage

// File: rtl/dac_bcd_add.sv
module dac_bcd_add import dac_pkg::*; #(
  parameter int DIGITS = W_DIGITS
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  logic [DIGITS:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign {carry[g+1], sum[4*g +: 4]} =
      bcd_digit_add(a[4*g +: 4], b[4*g +: 4], carry[g]);
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/dac_mem.sv
module dac_mem import dac_pkg::*; #(
  parameter int unsigned DEPTH = 1000
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  int unsigned widx;
  int unsigned ridx;
  assign widx = bcd_to_index(waddr);
  assign ridx = bcd_to_index(raddr);

  always_ff @(posedge clk) begin
    if (we && widx < DEPTH) cells[widx] <= wdata;
  end

  assign rdata = (ridx < DEPTH) ? cells[ridx] : '0;
endmodule

// File: rtl/dec_acc_core.sv
module dec_acc_core import dac_pkg::*; #(
  parameter int unsigned       DEPTH        = 1000,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [WORD_W-1:0] dbg_ir,
  output logic [WORD_W-1:0] dbg_ac,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [WORD_W-1:0] dbg_mbr,
  output logic              dbg_ovf,
  output logic              dbg_in_isr,
  output logic [ADDR_W-1:0] dbg_sav_pc,
  output logic [WORD_W-1:0] dbg_sav_ac
);
  state_e            state;
  logic [ADDR_W-1:0] pc, mar, sav_pc;
  logic [WORD_W-1:0] ir, mbr, ac, sav_ac;
  logic              ovf, in_isr;

  // decoded instruction fields
  logic [3:0]        op;
  logic [ADDR_W-1:0] operand;
  logic              op_valid;
  assign op       = ir[WORD_W-1 -: 4];
  assign operand  = ir[ADDR_W-1:0];
  assign op_valid = (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD);

  // named events, visible to the bound checker
  logic irq_take;
  logic core_we;
  assign irq_take = (state == S_CHK) && irq && !in_isr;
  assign core_we  = (state == S_XFIN) && (op == OP_STORE);

  // memory: loader owns the write port while reset is held
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  assign mem_we    = rst_n ? core_we : ld_en;
  assign mem_waddr = rst_n ? mar     : ld_addr;
  assign mem_wdata = rst_n ? mbr     : ld_data;

  dac_mem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (mem_rdata)
  );

  logic [WORD_W-1:0] sum;
  logic              sum_cout;
  dac_bcd_add #(.DIGITS(W_DIGITS)) u_add (
    .a    (ac),
    .b    (mbr),
    .sum  (sum),
    .cout (sum_cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_FMAR;
      pc     <= '0;
      mar    <= '0;
      ir     <= '0;
      mbr    <= '0;
      ac     <= '0;
      ovf    <= 1'b0;
      in_isr <= 1'b0;
      sav_pc <= '0;
      sav_ac <= '0;
    end else begin
      case (state)
        S_FMAR: begin
          mar   <= pc;
          state <= S_FMBR;
        end
        S_FMBR: begin
          mbr   <= mem_rdata;
          state <= S_FIR;
        end
        S_FIR: begin
          ir    <= mbr;
          state <= S_FPC;
        end
        S_FPC: begin
          pc    <= bcd_inc_addr(pc);
          state <= op_valid ? S_XMAR : S_HALT;
        end
        S_XMAR: begin
          mar   <= operand;
          state <= S_XMBR;
        end
        S_XMBR: begin
          mbr   <= (op == OP_STORE) ? ac : mem_rdata;
          state <= S_XFIN;
        end
        S_XFIN: begin
          if (op == OP_LOAD) ac <= mbr;
          if (op == OP_ADD) begin
            ac  <= sum;
            ovf <= sum_cout;
          end
          state <= S_CHK;
        end
        S_CHK: begin
          if (irq_take) begin
            sav_pc <= pc;
            sav_ac <= ac;
            pc     <= HANDLER_ADDR;
            in_isr <= 1'b1;
          end
          state <= S_FMAR;
        end
        S_HALT:  state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end

  assign halted     = (state == S_HALT);
  assign dbg_pc     = pc;
  assign dbg_ir     = ir;
  assign dbg_ac     = ac;
  assign dbg_mar    = mar;
  assign dbg_mbr    = mbr;
  assign dbg_ovf    = ovf;
  assign dbg_in_isr = in_isr;
  assign dbg_sav_pc = sav_pc;
  assign dbg_sav_ac = sav_ac;
endmodule

// File: rtl/dec_acc_core_chk.sv
module dec_acc_core_chk import dac_pkg::*; #(
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h900
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic              in_isr,
  input logic              irq_take,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] sav_pc,
  input logic [WORD_W-1:0] ac,
  input logic [WORD_W-1:0] sav_ac
);
  function automatic logic word_is_bcd(input logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < W_DIGITS; d++)
      if (w[4*d +: 4] > 4'd9) ok = 1'b0;
    word_is_bcd = ok;
  endfunction

  assert_halt_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(ac)));

  assert_isr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_isr |=> in_isr);

  assert_no_retake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_isr |-> !irq_take);

  assert_ctx_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (sav_pc == $past(pc) && sav_ac == $past(ac) && pc == HANDLER_ADDR));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == bcd_inc_addr($past(pc)) || pc == HANDLER_ADDR));

  assert_ac_decimal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_is_bcd(ac));
endmodule

bind dec_acc_core dec_acc_core_chk #(.HANDLER_ADDR(HANDLER_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .halted   (halted),
  .in_isr   (in_isr),
  .irq_take (irq_take),
  .pc       (pc),
  .sav_pc   (sav_pc),
  .ac       (ac),
  .sav_ac   (sav_ac)
);

// File: tb/dec_acc_core_tb.sv
module dec_acc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        halted, dbg_ovf, dbg_in_isr;
  logic [11:0] dbg_pc, dbg_mar, dbg_sav_pc;
  logic [15:0] dbg_ir, dbg_ac, dbg_mbr, dbg_sav_ac;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dec_acc_core #(.DEPTH(1000), .HANDLER_ADDR(12'h998)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_ac(dbg_ac),
    .dbg_mar(dbg_mar), .dbg_mbr(dbg_mbr), .dbg_ovf(dbg_ovf),
    .dbg_in_isr(dbg_in_isr), .dbg_sav_pc(dbg_sav_pc), .dbg_sav_ac(dbg_sav_ac)
  );

  function automatic logic [15:0] dec4(input int v);
    dec4 = {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic logic [11:0] dec3(input int v);
    dec3 = {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic poke(input int addr, input logic [15:0] val);
    ld_en = 1'b1;
    ld_addr = dec3(addr);
    ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // release reset (optionally driving the loader while running), count edges to halt
  task automatic run(input logic jam, input int jam_addr, input logic [15:0] jam_data,
                     output int n);
    rst_n = 1'b1;
    ld_en = jam;
    ld_addr = dec3(jam_addr);
    ld_data = jam_data;
    n = 0;
    while (!halted && n < 3000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic add_case(input int a, input int b);
    int n;
    int s;
    s = (a + b) % 10000;
    enter_reset();
    poke(0, 16'h1100);
    poke(1, 16'h3101);
    poke(2, 16'h2102);
    poke(3, 16'h1102);
    poke(4, 16'h0000);
    poke(100, dec4(a));
    poke(101, dec4(b));
    poke(102, dec4((a + b + 5000) % 10000));
    run(1'b1, 101, dec4((b + 1) % 10000), n);
    check("R4/R5/R9 stored sum reloaded", 32'(dbg_ac), 32'(dec4(s)));
    check("R4 overflow flag", 32'(dbg_ovf), 32'((a + b) >= 10000));
    check("R10 cycles for four instructions", 32'(n), 32'd36);
    check("R7 no handler without request", 32'(dbg_in_isr), 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int n;
    logic [3:0] halt_ops [7];
    halt_ops = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9};

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pc", 32'(dbg_pc), 32'd0);
    check("R1 ir", 32'(dbg_ir), 32'd0);
    check("R1 ac", 32'(dbg_ac), 32'd0);
    check("R1 mar", 32'(dbg_mar), 32'd0);
    check("R1 mbr", 32'(dbg_mbr), 32'd0);
    check("R1 halt/ovf/isr", {29'd0, halted, dbg_ovf, dbg_in_isr}, 32'd0);

    // R6, R3, R2, R10: each stopping opcode after one load
    foreach (halt_ops[k]) begin
      enter_reset();
      poke(0, 16'h1010);
      poke(1, {halt_ops[k], 12'h345});
      poke(10, 16'h0321);
      run(1'b0, 0, 16'h0, n);
      check("R6 halt raised", 32'(halted), 32'd1);
      check("R2 pc past stopping instruction", 32'(dbg_pc), 32'h002);
      check("R3 load result", 32'(dbg_ac), 32'h0321);
      check("R10 halt timing", 32'(n), 32'd12);
      repeat (5) @(negedge clk);
      check("R6 halt held", {halted, 4'd0, dbg_pc}, {1'b1, 4'd0, 12'h002});
    end

    // R4, R5, R9: sweep of operand pairs plus corners
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        add_case((i * 4349) % 10000, (j * 3571 + 6000) % 10000);
    add_case(9999, 1);
    add_case(9999, 9999);
    add_case(0, 0);
    add_case(5, 5);
    add_case(4999, 5000);

    // R7, R8, R2 wrap: handler at 998 runs through 999 into 000
    enter_reset();
    poke(0, 16'h1010);
    poke(1, 16'h1012);
    poke(2, 16'h0000);
    poke(10, 16'h0123);
    poke(11, 16'h0456);
    poke(12, 16'h0000);
    poke(998, 16'h3011);
    poke(999, 16'h2012);
    irq = 1'b1;
    run(1'b0, 0, 16'h0, n);
    irq = 1'b0;
    check("R7 saved pc", 32'(dbg_sav_pc), 32'h001);
    check("R7 saved ac", 32'(dbg_sav_ac), 32'h0123);
    check("R8 handler active", 32'(dbg_in_isr), 32'd1);
    check("R2 wrap then stop pc", 32'(dbg_pc), 32'h003);
    check("R5 handler store seen", 32'(dbg_ac), 32'h0579);
    check("R8 R10 no second entry", 32'(n), 32'd44);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule